// File: doc/BRIEF.md
# Tree Packet Bus Switch

This block is one node of a tree-shaped, full-duplex packet bus. It has a single port facing the parent node and `NDN` ports facing child subtrees. Each port has an input lane and an output lane that run independently of each other. A packet is a run of data words. A start flag marks the first word and an end flag marks the last. A word crosses any lane only in a cycle where the sender's valid and the receiver's ready are both high.

The first word of every packet is a header, and its low `DEST_W` bits carry a destination address. Child port `p` owns the addresses `BASE + p*SPAN` through `BASE + (p+1)*SPAN - 1`.
- A packet whose address falls in a child's range goes to that child, whichever port it came in on. Traffic between sibling subtrees therefore turns around at this node and never uses the parent link.
- A packet from a child whose address matches no range goes to the parent.
- A packet from the parent whose address matches no range is consumed and discarded.

Each output lane has its own round-robin arbiter and a register stage. The register stage breaks long wide routes between nodes. An output stays with one input from the start word to the end word of a packet.

Top module: `tpb_switch`

## Requirements
- R1: After a synchronous active-low reset, no output lane presents a valid word.
- R2: A packet whose header address (bits `[DEST_W-1:0]` of the first word) lies in a child port's range is delivered to that child's output lane. This holds for packets from any input. With the defaults, child 0 owns 16..19, child 1 owns 20..23 and child 2 owns 24..27.
- R3: A packet arriving from a child port whose address matches no child range leaves on the parent output lane.
- R4: A packet arriving from the parent whose address matches no child range is accepted and discarded: it appears on no output. The parent input keeps accepting packets that follow it.
- R5: A packet moving between two child ports never appears on the parent output lane.
- R6: A word moves only when valid and ready are both high. While an output presents a word that is not taken, its data and flags stay unchanged and no further word is pulled from the feeding input.
- R7: The output lanes are registered. A word accepted from an idle input at a clock edge first shows on the output lane in the following cycle.
- R8: Packets never interleave on an output lane. Once an input wins an output with a start word, it keeps that output until its end word has passed.
- R9: When several inputs keep contending for one output, whole packets are granted in rotating order. Each input's turn follows the input that was served last.
- R10: Packet data and flags are delivered unmodified. Packets from one input to one output keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole node |
| rst_n | input | 1 | Synchronous reset, active low |
| up_rx_data | input | DATA_W | Word arriving from the parent |
| up_rx_sop | input | 1 | Start flag of the arriving parent word |
| up_rx_eop | input | 1 | End flag of the arriving parent word |
| up_rx_src_rdy | input | 1 | Parent has a word on up_rx_data |
| up_rx_dst_rdy | output | 1 | Switch takes the parent word this cycle |
| up_tx_data | output | DATA_W | Word sent to the parent |
| up_tx_sop | output | 1 | Start flag of the word sent to the parent |
| up_tx_eop | output | 1 | End flag of the word sent to the parent |
| up_tx_src_rdy | output | 1 | A word is presented to the parent |
| up_tx_dst_rdy | input | 1 | Parent takes the presented word |
| dn_rx_data | input | NDN*DATA_W | Words arriving from the children, child p in slice p |
| dn_rx_sop | input | NDN | Start flags from the children |
| dn_rx_eop | input | NDN | End flags from the children |
| dn_rx_src_rdy | input | NDN | Child p has a word in its slice |
| dn_rx_dst_rdy | output | NDN | Switch takes child p's word this cycle |
| dn_tx_data | output | NDN*DATA_W | Words sent to the children, child p in slice p |
| dn_tx_sop | output | NDN | Start flags toward the children |
| dn_tx_eop | output | NDN | End flags toward the children |
| dn_tx_src_rdy | output | NDN | A word is presented to child p |
| dn_tx_dst_rdy | input | NDN | Child p takes the presented word |

## Verification
Some properties hold in every cycle, and these are covered by assertions:
- an output register loads whenever it has room and a granted word;
- a stalled output holds its word;
- each arbiter grants at most one input;
- no output ever shows a start word inside an open packet, or a middle word outside one;
- the parent input is never granted back toward the parent.

Other properties depend on addresses, timing and ordering, and only the bench scenarios can show them. These are where each address lands, that discarded and sibling packets stay off the parent lane, the one-cycle register latency, the rotation order under sustained three-way contention, and per-source ordering under random stalls on both sides.

// File: rtl/tpb_pkg.sv
// Shared definitions for the tree packet bus switch.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package tpb_pkg;

    // State of an output arbiter: open for a new packet or bound to one input
    typedef enum logic {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_mode_e;

    // Bits needed to hold an index below n (at least one bit)
    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tpb_route.sv
// Per-input route decoder.
// Decodes the destination field of a start word into an output index and
// keeps that index for the remaining words of the packet.
// Output index p < NDN is child p, NDN is the parent lane, and NDN+1 means
// discard (used only by the parent input).
// Assumes: every packet begins with a word whose sop flag is set.
module tpb_route #(
    parameter int DEST_W  = 8,
    parameter int NDN     = 3,
    parameter int BASE    = 16,
    parameter int SPAN    = 4,
    parameter int FROM_UP = 0,
    parameter int TW      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic              sop,
    input  logic              acc,
    input  logic [DEST_W-1:0] dest_f,
    output logic [TW-1:0]     tgt
);
    localparam int MISS = (FROM_UP != 0) ? NDN + 1 : NDN;

    logic [TW-1:0] held;
    logic [TW-1:0] dec;
    logic [31:0]   dest;

    // Range match of the header address against every child window
    always_comb begin
        dest = 32'(dest_f);
        dec  = TW'(MISS);
        for (int p = 0; p < NDN; p++) begin
            if (dest >= 32'(BASE + p * SPAN) && dest < 32'(BASE + (p + 1) * SPAN)) begin
                dec = TW'(p);
            end
        end
    end

    assign tgt = sop ? dec : held;

    // Remember the decoded route once the start word has been taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= TW'(MISS);
        end else if (vld && acc && sop) begin
            held <= dec;
        end
    end

endmodule

// File: rtl/tpb_arb.sv
// Round-robin arbiter for one output lane, locked for the length of a packet.
// While open it grants the first requester after the one served last.
// A start word that moves without its end flag binds the grant to that input
// until the end word moves.
// Assumes: xfer is high only when a granted, requesting word really moves.
module tpb_arb #(
    parameter int NIN = 4,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] req,
    input  logic           xfer,
    input  logic           xfer_eop,
    output logic [NIN-1:0] gnt
);
    import tpb_pkg::*;

    arb_mode_e     mode;
    logic [IW-1:0] owner;
    logic [IW-1:0] last;
    logic [IW-1:0] pick;
    logic [IW-1:0] cur;
    logic          pick_vld;

    // Search requesters starting one place after the last served input
    always_comb begin
        int idx;
        pick     = '0;
        pick_vld = 1'b0;
        for (int k = NIN; k >= 1; k--) begin
            idx = (int'(last) + k) % NIN;
            if (req[idx]) begin
                pick_vld = 1'b1;
                pick     = IW'(idx);
            end
        end
    end

    assign cur = (mode == ARB_HELD) ? owner : pick;

    // Grant vector: the bound owner, or the chosen requester when open
    always_comb begin
        gnt = '0;
        if (mode == ARB_HELD) begin
            gnt[owner] = 1'b1;
        end else if (pick_vld) begin
            gnt[pick] = 1'b1;
        end
    end

    // Bind on a start word, release and advance the pointer on an end word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= ARB_OPEN;
            owner <= '0;
            last  <= IW'(NIN - 1);
        end else if (xfer) begin
            if (xfer_eop) begin
                mode <= ARB_OPEN;
                last <= cur;
            end else begin
                mode  <= ARB_HELD;
                owner <= cur;
            end
        end
    end

    assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

endmodule

// File: rtl/tpb_outreg.sv
// Registered output stage of one lane.
// Loads a new word whenever it is empty or its word is being taken.
// Holds the word unchanged while the receiver stalls.
// Assumes: in_vld is only raised for a word that will be taken when space is high.
module tpb_outreg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              space,
    output logic              tx_vld,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    input  logic              dst_rdy
);
    assign space = !tx_vld || dst_rdy;

    // Valid flag follows the incoming word whenever the stage can advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_vld <= 1'b0;
        end else if (space) begin
            tx_vld <= in_vld;
        end
    end

    // Capture data and flags of the word being loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= '0;
            tx_sop  <= 1'b0;
            tx_eop  <= 1'b0;
        end else if (space && in_vld) begin
            tx_data <= in_data;
            tx_sop  <= in_sop;
            tx_eop  <= in_eop;
        end
    end

    assert_load_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && space |=> tx_vld);

    assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld && !dst_rdy |=> tx_vld && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

endmodule

// File: rtl/tpb_switch.sv
// Tree packet bus switch node: one parent port and NDN child ports, all full duplex.
// Each input gets a route decoder. Each output gets a round-robin arbiter
// and a register stage. Input NDN and output NDN are the parent side.
// Assumes: well-formed packets (sop first, eop last, header address in the
// low DEST_W bits of the first word) and DATA_W of 64 or 128.
module tpb_switch #(
    parameter int DATA_W = 64,
    parameter int NDN    = 3,
    parameter int DEST_W = 8,
    parameter int BASE   = 16,
    parameter int SPAN   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     up_rx_data,
    input  logic                  up_rx_sop,
    input  logic                  up_rx_eop,
    input  logic                  up_rx_src_rdy,
    output logic                  up_rx_dst_rdy,
    output logic [DATA_W-1:0]     up_tx_data,
    output logic                  up_tx_sop,
    output logic                  up_tx_eop,
    output logic                  up_tx_src_rdy,
    input  logic                  up_tx_dst_rdy,
    input  logic [NDN*DATA_W-1:0] dn_rx_data,
    input  logic [NDN-1:0]        dn_rx_sop,
    input  logic [NDN-1:0]        dn_rx_eop,
    input  logic [NDN-1:0]        dn_rx_src_rdy,
    output logic [NDN-1:0]        dn_rx_dst_rdy,
    output logic [NDN*DATA_W-1:0] dn_tx_data,
    output logic [NDN-1:0]        dn_tx_sop,
    output logic [NDN-1:0]        dn_tx_eop,
    output logic [NDN-1:0]        dn_tx_src_rdy,
    input  logic [NDN-1:0]        dn_tx_dst_rdy
);
    localparam int NIN  = NDN + 1;
    localparam int NOUT = NDN + 1;
    localparam int UP   = NDN;
    localparam int DROP = NDN + 1;
    localparam int TW   = tpb_pkg::idx_w(NDN + 2);
    localparam int IW   = tpb_pkg::idx_w(NIN);

    logic [DATA_W-1:0] i_data [NIN];
    logic [NIN-1:0]    i_vld, i_sop, i_eop, i_rdy;
    logic [TW-1:0]     i_tgt [NIN];

    logic [NIN-1:0]    o_req [NOUT];
    logic [NIN-1:0]    o_gnt [NOUT];
    logic [NOUT-1:0]   o_space, o_xfer, o_vld_in, o_sel_sop, o_sel_eop;
    logic [DATA_W-1:0] o_sel_data [NOUT];

    logic [NOUT-1:0]   tx_vld, tx_sop, tx_eop, tx_rdy;
    logic [DATA_W-1:0] tx_data [NOUT];

    // Gather child and parent input lanes into one indexed set
    always_comb begin
        for (int i = 0; i < NDN; i++) begin
            i_data[i] = dn_rx_data[i*DATA_W +: DATA_W];
            i_vld[i]  = dn_rx_src_rdy[i];
            i_sop[i]  = dn_rx_sop[i];
            i_eop[i]  = dn_rx_eop[i];
        end
        i_data[UP] = up_rx_data;
        i_vld[UP]  = up_rx_src_rdy;
        i_sop[UP]  = up_rx_sop;
        i_eop[UP]  = up_rx_eop;
    end

    // One route decoder per input; the parent input discards unmatched packets
    for (genvar gi = 0; gi < NIN; gi++) begin : g_in
        tpb_route #(
            .DEST_W (DEST_W),
            .NDN    (NDN),
            .BASE   (BASE),
            .SPAN   (SPAN),
            .FROM_UP((gi == UP) ? 1 : 0),
            .TW     (TW)
        ) u_route (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (i_vld[gi]),
            .sop   (i_sop[gi]),
            .acc   (i_rdy[gi]),
            .dest_f(i_data[gi][DEST_W-1:0]),
            .tgt   (i_tgt[gi])
        );
    end

    // Request matrix: input i asks for output o when its route points there
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            for (int i = 0; i < NIN; i++) begin
                o_req[o][i] = i_vld[i] && (i_tgt[i] == TW'(o));
            end
        end
    end

    // Crossbar: pass the granted input's word toward each output register
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            o_vld_in[o]   = 1'b0;
            o_sel_data[o] = '0;
            o_sel_sop[o]  = 1'b0;
            o_sel_eop[o]  = 1'b0;
            for (int i = 0; i < NIN; i++) begin
                if (o_gnt[o][i] && o_req[o][i]) begin
                    o_vld_in[o]   = 1'b1;
                    o_sel_data[o] = i_data[i];
                    o_sel_sop[o]  = i_sop[i];
                    o_sel_eop[o]  = i_eop[i];
                end
            end
            o_xfer[o] = o_vld_in[o] && o_space[o];
        end
    end

    // Input ready: granted with room at its output, or routed to discard
    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            i_rdy[i] = (i_tgt[i] == TW'(DROP));
            for (int o = 0; o < NOUT; o++) begin
                if (o_gnt[o][i] && (i_tgt[i] == TW'(o)) && o_space[o]) begin
                    i_rdy[i] = 1'b1;
                end
            end
        end
    end

    assign tx_rdy = {up_tx_dst_rdy, dn_tx_dst_rdy};

    // One arbiter and one register stage per output lane
    for (genvar go = 0; go < NOUT; go++) begin : g_out
        tpb_arb #(
            .NIN(NIN),
            .IW (IW)
        ) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (o_req[go]),
            .xfer    (o_xfer[go]),
            .xfer_eop(o_sel_eop[go]),
            .gnt     (o_gnt[go])
        );

        tpb_outreg #(
            .DATA_W(DATA_W)
        ) u_oreg (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (o_vld_in[go]),
            .in_data(o_sel_data[go]),
            .in_sop (o_sel_sop[go]),
            .in_eop (o_sel_eop[go]),
            .space  (o_space[go]),
            .tx_vld (tx_vld[go]),
            .tx_data(tx_data[go]),
            .tx_sop (tx_sop[go]),
            .tx_eop (tx_eop[go]),
            .dst_rdy(tx_rdy[go])
        );
    end

    // Child output lanes onto the flat port vectors
    for (genvar gd = 0; gd < NDN; gd++) begin : g_dn
        assign dn_tx_data[gd*DATA_W +: DATA_W] = tx_data[gd];
    end
    assign dn_tx_sop     = tx_sop[NDN-1:0];
    assign dn_tx_eop     = tx_eop[NDN-1:0];
    assign dn_tx_src_rdy = tx_vld[NDN-1:0];
    assign dn_rx_dst_rdy = i_rdy[NDN-1:0];

    assign up_tx_data    = tx_data[UP];
    assign up_tx_sop     = tx_sop[UP];
    assign up_tx_eop     = tx_eop[UP];
    assign up_tx_src_rdy = tx_vld[UP];
    assign up_rx_dst_rdy = i_rdy[UP];

    // Packet-open tracker per output lane, used only by the framing checks
    logic [NOUT-1:0] mon_open;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_open <= '0;
        end else begin
            for (int o = 0; o < NOUT; o++) begin
                if (tx_vld[o] && tx_rdy[o]) begin
                    mon_open[o] <= !tx_eop[o];
                end
            end
        end
    end

    for (genvar ga = 0; ga < NOUT; ga++) begin : g_chk
        assert_no_interleave_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tx_vld[ga] && tx_rdy[ga] && mon_open[ga] |-> !tx_sop[ga]);
        assert_sop_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tx_vld[ga] && tx_rdy[ga] && !mon_open[ga] |-> tx_sop[ga]);
    end

    assert_no_echo_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(o_gnt[UP][UP] && o_req[UP][UP]));

endmodule

// File: tb/sim_tpb_switch.sv
`timescale 1ns/1ps
module sim_tpb_switch;
    localparam int DW  = 64;
    localparam int ND  = 3;
    localparam int NI  = ND + 1;
    localparam int UPI = ND;

    typedef logic [DW+1:0] word_t;   // {sop, eop, data}
    typedef logic [DW+3:0] exp_t;    // {src[1:0], sop, eop, data}

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [DW-1:0]   b_data [NI];
    logic [NI-1:0]   b_vld, b_sop, b_eop, b_rdy;
    logic [NI-1:0]   t_vld, t_sop, t_eop, t_rdy;
    logic [DW-1:0]   t_data [NI];
    logic [ND*DW-1:0] dn_tx_data_w;
    logic [DW-1:0]   up_tx_data_w;

    tpb_switch u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_rx_data   (b_data[UPI]),
        .up_rx_sop    (b_sop[UPI]),
        .up_rx_eop    (b_eop[UPI]),
        .up_rx_src_rdy(b_vld[UPI]),
        .up_rx_dst_rdy(b_rdy[UPI]),
        .up_tx_data   (up_tx_data_w),
        .up_tx_sop    (t_sop[UPI]),
        .up_tx_eop    (t_eop[UPI]),
        .up_tx_src_rdy(t_vld[UPI]),
        .up_tx_dst_rdy(t_rdy[UPI]),
        .dn_rx_data   ({b_data[2], b_data[1], b_data[0]}),
        .dn_rx_sop    (b_sop[ND-1:0]),
        .dn_rx_eop    (b_eop[ND-1:0]),
        .dn_rx_src_rdy(b_vld[ND-1:0]),
        .dn_rx_dst_rdy(b_rdy[ND-1:0]),
        .dn_tx_data   (dn_tx_data_w),
        .dn_tx_sop    (t_sop[ND-1:0]),
        .dn_tx_eop    (t_eop[ND-1:0]),
        .dn_tx_src_rdy(t_vld[ND-1:0]),
        .dn_tx_dst_rdy(t_rdy[ND-1:0])
    );

    always_comb begin
        for (int g = 0; g < ND; g++) t_data[g] = dn_tx_data_w[g*DW +: DW];
        t_data[UPI] = up_tx_data_w;
    end

    // Reference state: stimulus queues, expected words per output, counters
    word_t inq [NI][$];
    exp_t  expq [NI][$];
    int    uplog [$];
    int    cur_dst [NI];
    int    cur_src [NI];
    bit    opn [NI];
    int    outw [NI];
    int    ndrop = 0;
    int    serial = 0;
    int    nvec = 0;
    int    nfail = 0;
    bit    rand_mode = 1'b0;
    logic [NI-1:0] rdy_pat = '1;

    function automatic int route(int src, int d);
        for (int p = 0; p < ND; p++) if (d >= 16 + 4 * p && d < 20 + 4 * p) return p;
        return (src == UPI) ? -1 : UPI;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic send_pkt(int src, int dest, int len);
        for (int w = 0; w < len; w++) begin
            logic [DW-1:0] d;
            d = {16'h0, 16'(w), 16'(serial), 8'(src), 8'(dest)};
            inq[src].push_back({(w == 0), (w == len - 1), d});
        end
        serial++;
    endtask

    // Compare one word leaving output o against the behavioural expectation
    task automatic check_out(int o);
        word_t w;
        int hit;
        int s;
        w = {t_sop[o], t_eop[o], t_data[o]};
        outw[o]++;
        nvec++;
        hit = -1;
        if (!opn[o]) begin
            for (int k = 0; k < expq[o].size(); k++) begin
                if (expq[o][k][DW+1:0] == w && w[DW+1]) begin hit = k; break; end
            end
            if (hit < 0) begin
                nfail++;
                $display("FAIL R2 out=%0d unexpected start word actual=%h expected=none", o, w);
            end else begin
                s = int'(expq[o][hit][DW+3:DW+2]);
                for (int k = 0; k < hit; k++) begin
                    if (int'(expq[o][k][DW+3:DW+2]) == s) begin
                        nfail++;
                        $display("FAIL R10 out=%0d order actual=%h expected=%h", o, w, expq[o][k][DW+1:0]);
                        break;
                    end
                end
                cur_src[o] = s;
                if (o == UPI) uplog.push_back(s);
                expq[o].delete(hit);
                opn[o] = !w[DW];
            end
        end else begin
            for (int k = 0; k < expq[o].size(); k++) begin
                if (int'(expq[o][k][DW+3:DW+2]) == cur_src[o]) begin hit = k; break; end
            end
            if (hit < 0) begin
                nfail++;
                $display("FAIL R8 out=%0d stray word actual=%h expected=none", o, w);
            end else if (expq[o][hit][DW+1:0] != w) begin
                nfail++;
                $display("FAIL R8 out=%0d packet word actual=%h expected=%h", o, w, expq[o][hit][DW+1:0]);
                expq[o].delete(hit);
            end else begin
                expq[o].delete(hit);
                opn[o] = !w[DW];
            end
        end
    endtask

    // One clock: drive at the falling edge, sample just before the rising edge
    task automatic step();
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            if (inq[i].size() > 0 && !(rand_mode && $urandom_range(0, 3) == 0)) begin
                b_vld[i]  = 1'b1;
                b_sop[i]  = inq[i][0][DW+1];
                b_eop[i]  = inq[i][0][DW];
                b_data[i] = inq[i][0][DW-1:0];
            end else begin
                b_vld[i]  = 1'b0;
                b_sop[i]  = 1'b0;
                b_eop[i]  = 1'b0;
                b_data[i] = '0;
            end
        end
        for (int o = 0; o < NI; o++) begin
            t_rdy[o] = rand_mode ? ($urandom_range(0, 2) != 0) : rdy_pat[o];
        end
        #8;
        for (int i = 0; i < NI; i++) begin
            if (b_vld[i] && b_rdy[i]) begin
                word_t w;
                w = inq[i].pop_front();
                if (w[DW+1]) cur_dst[i] = route(i, int'(w[7:0]));
                if (cur_dst[i] >= 0) expq[cur_dst[i]].push_back({2'(i), w});
                else ndrop++;
            end
        end
        for (int o = 0; o < NI; o++) begin
            if (t_vld[o] && t_rdy[o]) check_out(o);
        end
    endtask

    function automatic bit busy();
        if (t_vld != '0) return 1'b1;
        for (int i = 0; i < NI; i++) if (inq[i].size() > 0 || expq[i].size() > 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic drain(string req);
        int n;
        n = 0;
        while (busy() && n < 5000) begin step(); n++; end
        chk(!busy(), req, "drain left words behind", n, 0);
    endtask

    task automatic clear_counts();
        for (int o = 0; o < NI; o++) outw[o] = 0;
        ndrop = 0;
    endtask

    initial begin
        #3_000_000;
        nfail++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NI; i++) begin
            b_data[i] = '0; cur_dst[i] = 0; cur_src[i] = 0; opn[i] = 1'b0; outw[i] = 0;
        end
        b_vld = '0; b_sop = '0; b_eop = '0; t_rdy = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #8;
        // R1: no output valid straight after reset
        for (int o = 0; o < NI; o++) chk(t_vld[o] == 1'b0, "R1", "output valid after reset", t_vld[o], 0);

        // R7: single-word packet, parent to child 1, shows one cycle after acceptance
        send_pkt(UPI, 21, 1);
        step();
        chk(inq[UPI].size() == 0, "R7", "word accepted by idle switch", inq[UPI].size(), 0);
        chk(t_vld[1] == 1'b0, "R7", "output before register edge", t_vld[1], 0);
        step();
        chk(t_vld[1] == 1'b1, "R7", "output one cycle after acceptance", t_vld[1], 1);
        drain("R7");

        // R2: parent traffic to every child window edge
        send_pkt(UPI, 16, 3);
        send_pkt(UPI, 23, 2);
        send_pkt(UPI, 27, 4);
        send_pkt(UPI, 19, 1);
        drain("R2");

        // R3 and R5: unmatched child traffic goes up, sibling traffic stays local
        clear_counts();
        send_pkt(0, 200, 3);
        send_pkt(1, 17, 2);
        send_pkt(0, 26, 2);
        send_pkt(2, 22, 2);
        drain("R3");
        chk(outw[UPI] == 3, "R5", "words on parent lane", outw[UPI], 3);
        chk(outw[0] == 2 && outw[1] == 2 && outw[2] == 2, "R5", "sibling words delivered", outw[0] + outw[1] + outw[2], 6);

        // R4: unmatched parent traffic is discarded and the lane keeps flowing
        clear_counts();
        send_pkt(UPI, 5, 3);
        drain("R4");
        chk(ndrop == 3, "R4", "words discarded", ndrop, 3);
        chk(outw[0] + outw[1] + outw[2] + outw[UPI] == 0, "R4", "words seen on outputs", outw[0] + outw[1] + outw[2] + outw[UPI], 0);
        send_pkt(UPI, 18, 2);
        drain("R4");
        chk(outw[0] == 2, "R4", "packet after discard delivered", outw[0], 2);

        // R6: stalled child output holds its word and backs up the input
        rdy_pat[2] = 1'b0;
        send_pkt(UPI, 25, 4);
        step();
        step();
        begin
            logic [DW-1:0] first;
            first = t_data[2];
            chk(t_vld[2] == 1'b1, "R6", "stalled output valid", t_vld[2], 1);
            for (int n = 0; n < 5; n++) begin
                step();
                chk(t_vld[2] == 1'b1 && t_data[2] == first, "R6", "stalled word stable", t_data[2], first);
                chk(inq[UPI].size() == 3, "R6", "words held at input", inq[UPI].size(), 3);
            end
        end
        rdy_pat[2] = 1'b1;
        drain("R6");

        // R9: three children contend for the parent lane
        uplog.delete();
        for (int r = 0; r < 3; r++) for (int c = 0; c < ND; c++) send_pkt(c, 250 + c, 2);
        drain("R9");
        chk(uplog.size() == 9, "R9", "packets on parent lane", uplog.size(), 9);
        for (int k = 1; k < uplog.size(); k++) begin
            chk(uplog[k] == (uplog[k-1] + 1) % ND, "R9", "rotation order", uplog[k], (uplog[k-1] + 1) % ND);
        end

        // R10 and R8: random traffic with random stalls on both sides
        rand_mode = 1'b1;
        for (int n = 0; n < 300; n++) begin
            int src;
            int r;
            int d;
            src = $urandom_range(0, NI - 1);
            r = $urandom_range(0, 13);
            d = (r < 12) ? 16 + r : ((r == 12) ? 100 : 3);
            send_pkt(src, d, $urandom_range(1, 5));
        end
        drain("R10");
        rand_mode = 1'b0;
        t_rdy = '1;
        for (int o = 0; o < NI; o++) chk(expq[o].size() == 0, "R10", "undelivered words", expq[o].size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule